// File: doc/BRIEF.md
# Range-Adaptive Booth Multiply-Accumulate Unit

This block computes `x*y + z` on signed two's-complement operands and holds the answer in a result register of the accumulator width. The block first measures how many significant bits each operand carries, meaning its width once redundant copies of the sign bit are removed. The narrower of `x` and `y` is recoded into radix-4 Booth digits. Fewer significant multiplier bits give more zero digits and so less switching in the partial-product rows.

The partial products are compressed into a carry-save pair with full-adder (3:2) cells only. The block then estimates the width of the product and compares it with the width of `z`. The larger of the two, plus one guard bit, becomes the effective word length of the accumulate addition. The result register is split into segments. A segment that lies wholly above the effective word length is not written and keeps its previous contents. On the way out, the bit at the top of the effective word length is copied into every upper bit, which restores the full-width value.

The unit is a two-stage pipeline with no back-pressure. Stage one does range detection, operand steering and Booth compression. Stage two does the effective-width addition and sign re-extension. A valid flag travels with the data.

Top module: `range_mac`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `result` is 0 until the first valid operation has come out.
- R2: An operation accepted with `in_valid`=1 at a rising edge appears two rising edges later with `out_valid`=1. Its `result` is `x*y+z` reduced modulo 2^ZW, with `x`, `y` and `z` read as signed two's-complement numbers.
- R3: The effective width of a value is the smallest n ≥ 1 for which it fits an n-bit signed number. The operand with the smaller effective width is Booth-recoded, and `y` is recoded on a tie. The result does not depend on which operand is recoded.
- R4: The effective addition width is min(ZW, max(wx+wy+1, wz)+1), where wx, wy and wz are the effective widths of `x`, `y` and `z`. It is never smaller than the effective width of the true result.
- R5: Result-register segments of SEG bits (segment k covers bits k*SEG upward) whose lowest bit is at or above the effective addition width keep their previous contents. Stale contents there never show in `result`.
- R6: Every `result` bit at or above the effective addition width equals the bit just below that width, so a narrow negative result that follows a wide positive one is fully sign-extended.
- R7: A cycle with `in_valid`=0 gives `out_valid`=0 two edges later. While no valid operation comes out, `result` keeps the last value that was output.
- R8: Extreme operands give the exact modular result, including `x`=`y`=-2^(XW-1), the most negative and most positive `z`, and sums that wrap at ZW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on `x`, `y`, `z` are to be processed |
| x | input | XW (16) | First signed factor |
| y | input | XW (16) | Second signed factor |
| z | input | ZW (40) | Signed addend |
| out_valid | output | 1 | `result` carries a new operation's value |
| result | output | ZW (40) | Signed `x*y+z`, sign-extended from the effective width |

## Verification
Directed cases steer the Booth recoder each way: a narrow `x` against a wide `y`, the reverse, and equal widths. A mismatch there would expose a wrong swap or a wrong tie rule. Further cases let a wide `z` dominate a narrow product and a wide product dominate a tiny `z`. Together these show whether the width estimate covers both sources of the sum and the carry out of the addition.

Wide negative and wide positive results are followed by narrow results of the opposite sign. These pairs reveal any upper segment that leaks stale bits or any missing sign copy. Pipeline bubbles show whether the output holds its value. Random operands whose effective widths are spread by arithmetic shifts, together with random gaps in `in_valid`, cover the general case. Most-negative factors and wrapping sums cover the edges of the number range.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

   typedef enum logic [2:0] {
      BD_ZERO = 3'd0,
      BD_POS1 = 3'd1,
      BD_POS2 = 3'd2,
      BD_NEG1 = 3'd3,
      BD_NEG2 = 3'd4
   } booth_op_e;

   // Smallest n such that v lies in the n-bit signed range (arithmetic form).
   function automatic int fit_width(longint v, int w);
      for (int n = 1; n < w; n++) begin
         if (v >= -(64'sd1 <<< (n - 1)) && v < (64'sd1 <<< (n - 1)))
            return n;
      end
      return w;
   endfunction

endpackage

// File: rtl/rmac_range_det.sv
module rmac_range_det #(
   parameter int W  = 16,
   parameter int WB = 6
) (
   input  logic [W-1:0]  v,
   output logic [WB-1:0] width
);

   // Scan down from the top: each bit equal to its upper neighbour is a
   // redundant sign copy; the first difference ends the run.
   always_comb begin
      logic run;
      run   = 1'b1;
      width = WB'(W);
      for (int k = W - 2; k >= 0; k--) begin
         run = run & (v[k] == v[k+1]);
         if (run) width = WB'(k + 1);
      end
   end

endmodule

// File: rtl/rmac_booth_csa.sv
module rmac_booth_csa
   import rmac_pkg::*;
#(
   parameter int MW = 16,
   parameter int OW = 40
) (
   input  logic [MW-1:0] mcand,
   input  logic [MW-1:0] mplr,
   output logic [OW-1:0] sum,
   output logic [OW-1:0] carry
);

   localparam int ND = MW / 2;

   logic [OW-1:0] a_ext;
   logic [MW:0]   bx;
   logic [ND-1:0] negv;
   logic [OW-1:0] negrow;

   assign a_ext = {{(OW - MW){mcand[MW-1]}}, mcand};
   assign bx    = {mplr, 1'b0};

   genvar i;
   generate
      for (i = 0; i < ND; i++) begin : g_dig
         booth_op_e     op;
         logic [OW-1:0] mag;
         logic [OW-1:0] row;

         always_comb begin
            unique case (bx[2*i+2 -: 3])
               3'b001, 3'b010: op = BD_POS1;
               3'b011:         op = BD_POS2;
               3'b100:         op = BD_NEG2;
               3'b101, 3'b110: op = BD_NEG1;
               default:        op = BD_ZERO;
            endcase
         end

         always_comb begin
            case (op)
               BD_POS1, BD_NEG1: mag = a_ext;
               BD_POS2, BD_NEG2: mag = a_ext << 1;
               default:          mag = '0;
            endcase
         end

         assign negv[i] = (op == BD_NEG1) || (op == BD_NEG2);
         // Negative digit: one's complement here, the +1 rides in negrow.
         assign row = negv[i] ? ((~mag) << (2 * i)) : (mag << (2 * i));
      end
   endgenerate

   always_comb begin
      negrow = '0;
      for (int k = 0; k < ND; k++) negrow[2*k] = negv[k];
   end

   // Linear carry-save chain built from full-adder cells only.
   logic [OW-1:0] cs_s [ND];
   logic [OW-1:0] cs_c [ND];

   assign cs_s[0] = g_dig[0].row;
   assign cs_c[0] = negrow;

   genvar r;
   generate
      for (r = 1; r < ND; r++) begin : g_csa
         logic [OW-1:0] a, b, d;
         assign a = cs_s[r-1];
         assign b = cs_c[r-1];
         assign d = g_dig[r].row;
         assign cs_s[r] = a ^ b ^ d;
         assign cs_c[r] = ((a & b) | (a & d) | (b & d)) << 1;
      end
   endgenerate

   assign sum   = cs_s[ND-1];
   assign carry = cs_c[ND-1];

endmodule

// File: rtl/rmac_seg_adder.sv
module rmac_seg_adder #(
   parameter int OW  = 40,
   parameter int WB  = 6,
   parameter int SEG = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [OW-1:0]   s,
   input  logic [OW-1:0]   c,
   input  logic [OW-1:0]   z,
   input  logic [WB-1:0]   wid,
   output logic            vld_q,
   output logic [OW-1:0]   acc_q,
   output logic [(OW+SEG-1)/SEG-1:0] seg_en,
   output logic [OW-1:0]   result
);

   localparam int NSEG = (OW + SEG - 1) / SEG;

   logic [OW-1:0] t3, u3, total;
   logic [WB-1:0] wid_q;

   // Fold the addend into the carry-save pair, then one carry-propagate add.
   assign t3    = s ^ c ^ z;
   assign u3    = ((s & c) | (s & z) | (c & z)) << 1;
   assign total = t3 + u3;

   genvar k;
   generate
      for (k = 0; k < NSEG; k++) begin : g_seg
         localparam int LO = k * SEG;
         localparam int HI = (LO + SEG > OW) ? OW - 1 : LO + SEG - 1;
         logic [HI-LO:0] q;

         assign seg_en[k] = (wid > WB'(LO));

         always_ff @(posedge clk) begin
            if (!rst_n)                q <= '0;
            else if (en && seg_en[k]) q <= total[HI:LO];
         end

         assign acc_q[HI:LO] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         wid_q <= WB'(1);
      end else begin
         vld_q <= en;
         if (en) wid_q <= wid;
      end
   end

   // Sign re-extension from the top effective bit.
   always_comb begin
      logic sb;
      sb = acc_q[wid_q - WB'(1)];
      for (int i = 0; i < OW; i++)
         result[i] = (WB'(i) < wid_q) ? acc_q[i] : sb;
   end

endmodule

// File: rtl/range_mac.sv
module range_mac #(
   parameter int XW  = 16,
   parameter int ZW  = 40,
   parameter int SEG = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [XW-1:0] x,
   input  logic [XW-1:0] y,
   input  logic [ZW-1:0] z,
   output logic          out_valid,
   output logic [ZW-1:0] result
);

   localparam int WB   = $clog2(ZW + 2);
   localparam int NSEG = (ZW + SEG - 1) / SEG;

   generate
      if (XW % 2 != 0 || XW < 4) begin : g_bad_xw
         $error("range_mac: XW must be even and at least 4");
      end
      if (ZW < 2 * XW + 1 || ZW > 64) begin : g_bad_zw
         $error("range_mac: ZW must lie in 2*XW+1 .. 64");
      end
      if (SEG < 1 || SEG > ZW) begin : g_bad_seg
         $error("range_mac: SEG must lie in 1 .. ZW");
      end
   endgenerate

   logic [WB-1:0] wx, wy, wz;

   rmac_range_det #(.W(XW), .WB(WB)) u_rx (.v(x), .width(wx));
   rmac_range_det #(.W(XW), .WB(WB)) u_ry (.v(y), .width(wy));
   rmac_range_det #(.W(ZW), .WB(WB)) u_rz (.v(z), .width(wz));

   // Narrower operand drives the recoder; y wins a tie.
   logic          take_y;
   logic [XW-1:0] mplr, mcand;
   assign take_y = (wy <= wx);
   assign mplr   = take_y ? y : x;
   assign mcand  = take_y ? x : y;

   logic [ZW-1:0] ps, pc;
   rmac_booth_csa #(.MW(XW), .OW(ZW)) u_mul (
      .mcand (mcand),
      .mplr  (mplr),
      .sum   (ps),
      .carry (pc)
   );

   logic [WB-1:0] pest, big, wid_d;
   assign pest  = wx + wy + WB'(1);
   assign big   = (pest > wz) ? pest : wz;
   assign wid_d = (big >= WB'(ZW)) ? WB'(ZW) : big + WB'(1);

   logic          s1_valid;
   logic [ZW-1:0] s1_s, s1_c, s1_z;
   logic [WB-1:0] s1_wid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_s     <= '0;
         s1_c     <= '0;
         s1_z     <= '0;
         s1_wid   <= WB'(1);
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_s   <= ps;
            s1_c   <= pc;
            s1_z   <= z;
            s1_wid <= wid_d;
         end
      end
   end

   logic [ZW-1:0]   acc_q;
   logic [NSEG-1:0] seg_en;

   rmac_seg_adder #(.OW(ZW), .WB(WB), .SEG(SEG)) u_add (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (s1_valid),
      .s      (s1_s),
      .c      (s1_c),
      .z      (s1_z),
      .wid    (s1_wid),
      .vld_q  (out_valid),
      .acc_q  (acc_q),
      .seg_en (seg_en),
      .result (result)
   );

endmodule

// File: rtl/rmac_chk.sv
module rmac_chk
   import rmac_pkg::*;
#(
   parameter int XW  = 16,
   parameter int ZW  = 40,
   parameter int SEG = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic [XW-1:0]               x,
   input logic [XW-1:0]               y,
   input logic [ZW-1:0]               z,
   input logic                        out_valid,
   input logic [ZW-1:0]               result,
   input logic [XW-1:0]               mplr,
   input logic [XW-1:0]               mcand,
   input logic                        s1_valid,
   input logic [$clog2(ZW+2)-1:0]     s1_wid,
   input logic [(ZW+SEG-1)/SEG-1:0]   seg_en,
   input logic [ZW-1:0]               acc_q
);

   localparam int NSEG = (ZW + SEG - 1) / SEG;

   logic [1:0] cyc;
   always_ff @(posedge clk) begin
      if (!rst_n)         cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   logic [ZW-1:0] refv;
   int            need_w, wmp, wmc;
   logic          pair_ok;
   logic [ZW-1:0] hmask;

   always_comb begin
      longint p;
      p = longint'($signed(x)) * longint'($signed(y)) + longint'($signed(z));
      refv   = p[ZW-1:0];
      need_w = fit_width(longint'($signed(refv)), ZW);
      wmp    = fit_width(longint'($signed(mplr)), XW);
      wmc    = fit_width(longint'($signed(mcand)), XW);
      pair_ok = (mplr == x && mcand == y) || (mplr == y && mcand == x);
      for (int i = 0; i < ZW; i++) hmask[i] = ~seg_en[i / SEG];
   end

   assert_valid_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

   assert_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && out_valid) |-> (result == $past(refv, 2)));

   assert_narrow_recode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (pair_ok && wmp <= wmc));

   assert_width_cover_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && s1_valid) |-> (int'(s1_wid) >= $past(need_w) && int'(s1_wid) <= ZW));

   assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> (((acc_q ^ $past(acc_q)) & $past(hmask)) == '0));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> $stable(acc_q));

endmodule

bind range_mac rmac_chk #(.XW(XW), .ZW(ZW), .SEG(SEG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .x         (x),
   .y         (y),
   .z         (z),
   .out_valid (out_valid),
   .result    (result),
   .mplr      (mplr),
   .mcand     (mcand),
   .s1_valid  (s1_valid),
   .s1_wid    (s1_wid),
   .seg_en    (seg_en),
   .acc_q     (acc_q)
);

// File: tb/sim_range_mac.sv
module sim_range_mac;

   localparam int CLK_PERIOD = 10;
   localparam int XW = 16;
   localparam int ZW = 40;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [XW-1:0] x, y;
   logic [ZW-1:0] z;
   logic          out_valid;
   logic [ZW-1:0] result;

   range_mac #(.XW(XW), .ZW(ZW), .SEG(8)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .x(x), .y(y), .z(z), .out_valid(out_valid), .result(result)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic          hv [2];
   logic [ZW-1:0] hr [2];
   string         ht [2];
   logic [ZW-1:0] last_res;

   function automatic logic [ZW-1:0] mac_model(logic [XW-1:0] a, logic [XW-1:0] b,
                                               logic [ZW-1:0] c);
      longint p;
      p = longint'($signed(a)) * longint'($signed(b)) + longint'($signed(c));
      return p[ZW-1:0];
   endfunction

   task automatic check(bit ok, string tag, logic [ZW-1:0] act, logic [ZW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Check the op issued two cycles ago, then drive the next one.
   task automatic step(bit v, logic [XW-1:0] a, logic [XW-1:0] b, logic [ZW-1:0] c,
                       string tag);
      @(negedge clk);
      check(out_valid == hv[1], hv[1] ? "R2 out_valid" : "R7 out_valid",
            ZW'(out_valid), ZW'(hv[1]));
      if (hv[1]) begin
         check(result == hr[1], ht[1], result, hr[1]);
         last_res = hr[1];
      end else begin
         check(result == last_res, "R7 hold", result, last_res);
      end
      hv[1] = hv[0]; hr[1] = hr[0]; ht[1] = ht[0];
      hv[0] = v;     hr[0] = mac_model(a, b, c); ht[0] = tag;
      in_valid = v; x = a; y = b; z = c;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      void'($urandom(32'h5EED));
      rst_n = 1'b0; in_valid = 1'b0; x = '0; y = '0; z = '0;
      hv[0] = 1'b0; hv[1] = 1'b0; hr[0] = '0; hr[1] = '0; ht[0] = ""; ht[1] = "";
      last_res = '0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", ZW'(out_valid), '0);
      check(result == '0, "R1 result in reset", result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && result == '0, "R1 after release", result, '0);

      // R8 extremes
      step(1, 16'h8000, 16'h8000, 40'h0, "R8 min*min");
      step(1, 16'h8000, 16'h7FFF, 40'h7F_FFFF_FFFF, "R8 max z");
      step(1, 16'h8000, 16'h8000, 40'h7F_FFFF_FFFF, "R8 wrap");
      step(1, 16'h7FFF, 16'h7FFF, 40'h80_0000_0000, "R8 min z");
      // R3 steering each way and tie
      step(1, 16'h0003, 16'h1234, 40'h5, "R3 narrow x");
      step(1, 16'hB3C1, 16'hFFFE, 40'h0, "R3 narrow y");
      step(1, 16'h00F0, 16'hFF10, 40'h1, "R3 tie");
      // R4 width sources
      step(1, 16'h0001, 16'hFFFF, 40'h12_3456_789A, "R4 wide z");
      step(1, 16'h7FFF, 16'h7FFF, 40'hFF_FFFF_FFFF, "R4 wide product");
      step(1, 16'h0000, 16'h0000, 40'h0, "R4 zero");
      // R5 stale upper segments, R6 sign copy
      step(1, 16'h0000, 16'h0000, 40'h80_0000_0001, "R5 wide negative");
      step(1, 16'h0001, 16'h0001, 40'h1, "R5 narrow after wide");
      step(1, 16'h0000, 16'h0000, 40'h7F_FFFF_FFFF, "R6 wide positive");
      step(1, 16'hFFFE, 16'h0003, 40'h0, "R6 narrow negative");
      step(1, 16'hFFFF, 16'h0001, 40'h0, "R6 minus one");
      // R7 bubbles with garbage operands
      step(0, 16'h1357, 16'h9BDF, 40'hAA_5555_AAAA, "R7 bubble");
      step(0, 16'hFFFF, 16'h8000, 40'h12_0000_0000, "R7 bubble");
      step(0, 16'h0, 16'h0, 40'h0, "R7 bubble");
      step(1, 16'h0002, 16'h0003, 40'hFF_FFFF_FFF0, "R7 resume");

      for (int n = 0; n < 3000; n++) begin
         logic signed [XW-1:0] a, b;
         logic signed [ZW-1:0] c;
         bit v;
         v = ($urandom % 5) != 0;
         a = XW'($urandom);
         b = XW'($urandom);
         c = {8'($urandom), 32'($urandom)};
         a = a >>> ($urandom % XW);
         b = b >>> ($urandom % XW);
         c = c >>> ($urandom % ZW);
         step(v, a, b, c, (n % 2 == 0) ? "R2 random" : "R3 random");
      end
      repeat (3) step(0, '0, '0, '0, "R7 flush");
      report();
   end

endmodule